// File: doc/BRIEF.md
# Burst Address Generator

This block produces the access address for one port of a synchronous memory array. On every cycle it picks one of four address sources: zero, the address presented on the external pins, the stored counter plus one, or the stored counter unchanged. The chosen address drives the memory in the same cycle and is also written into the counter register at the rising edge. A host can therefore present one starting address and then read or write a stream of consecutive words while only toggling a count-enable line.

Three active-low controls select the source with a fixed priority. Clear wins over everything, strobe (load) wins over count enable, and when none is asserted the counter holds. None of these choices costs an idle cycle. The counter covers the whole address space and wraps from the highest address back to zero. A design with two ports uses one instance per port.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous system reset `rst` is high at a rising edge, the counter becomes 0; right after reset `cnt_addr` reads 0.
- R2: When `clr_n` is low, `acc_addr` is 0 in that same cycle and the counter is 0 after the edge, whatever `strobe_n` and `step_n` are doing.
- R3: When `strobe_n` is low and `clr_n` is high, `acc_addr` equals `ext_addr` in that same cycle and the counter takes that value at the edge.
- R4: When `step_n` is low and both `strobe_n` and `clr_n` are high, `acc_addr` equals the counter plus one in that cycle and the counter advances to that value at the edge.
- R5: When `strobe_n`, `step_n` and `clr_n` are all high, `acc_addr` equals the counter, the counter keeps its value, and `ext_addr` has no effect.
- R6: Stepping from the all-ones address gives 0 (modulo 2^ADDR_W), both on `acc_addr` and in the counter.
- R7: A low `step_n` is ignored in a cycle where `strobe_n` is low: the loaded address is the external address itself, not the external address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous active-high system reset of the counter |
| ext_addr | input | ADDR_W | Externally supplied address |
| strobe_n | input | 1 | Active-low load: use and store `ext_addr` |
| step_n | input | 1 | Active-low count enable: use and store counter + 1 |
| clr_n | input | 1 | Active-low clear: use and store address 0 (highest priority) |
| acc_addr | output | ADDR_W | Address the memory uses in the current cycle (combinational) |
| cnt_addr | output | ADDR_W | Current counter register value |

## Verification
`acc_addr` is due in the same cycle as the controls, with no register on its path. `cnt_addr` is due one rising edge later. The bench changes inputs on the falling edge and samples both outputs shortly after. So in each step it compares `acc_addr` with the value chosen for the current controls, and `cnt_addr` with the address chosen in the step before. A wrap across the top address, clear and load during a burst, and a system reset in the middle of a run are driven as directed cases after the vector walk.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Address source chosen for the current cycle
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_STEP = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_ZERO = 2'd3
    } addr_src_e;

endpackage

// File: rtl/burst_src_arbiter.sv
module burst_src_arbiter
    import burst_addr_pkg::*;
(
    input  logic      strobe_n,
    input  logic      step_n,
    input  logic      clr_n,
    output addr_src_e src
);

    // Fixed priority: clear, then load, then step, else hold
    always_comb begin
        if (!clr_n) begin
            src = SRC_ZERO;
        end else if (!strobe_n) begin
            src = SRC_LOAD;
        end else if (!step_n) begin
            src = SRC_STEP;
        end else begin
            src = SRC_HOLD;
        end
    end

endmodule

// File: rtl/burst_addr_mux.sv
module burst_addr_mux
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  addr_src_e           src,
    input  logic [ADDR_W-1:0]   ext_addr,
    input  logic [ADDR_W-1:0]   cnt_addr,
    output logic [ADDR_W-1:0]   sel_addr
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] step_addr;

    // Natural overflow gives the wrap from the top address to zero
    assign step_addr = cnt_addr + ADDR_ONE;

    always_comb begin
        unique case (src)
            SRC_ZERO: sel_addr = '0;
            SRC_LOAD: sel_addr = ext_addr;
            SRC_STEP: sel_addr = step_addr;
            default:  sel_addr = cnt_addr;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cnt_addr
);

    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } gen_state_t;

    gen_state_t state_d, state_q;
    addr_src_e  src;
    logic [ADDR_W-1:0] sel_addr;

    burst_src_arbiter i_arb (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .src      (src)
    );

    burst_addr_mux #(
        .ADDR_W (ADDR_W)
    ) i_mux (
        .src      (src),
        .ext_addr (ext_addr),
        .cnt_addr (state_q.cnt),
        .sel_addr (sel_addr)
    );

    // Next value: the counter always stores the address used this cycle
    always_comb begin
        state_d     = state_q;
        state_d.cnt = sel_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_addr = sel_addr;
    assign cnt_addr = state_q.cnt;

    AST_SYS_RESET: assert property (@(posedge clk)
        rst |=> (cnt_addr == '0)); // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (cnt_addr == '0)); // R2

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !strobe_n) |=> (cnt_addr == $past(ext_addr))); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && !step_n) |=>
            (cnt_addr == ADDR_W'($past(cnt_addr) + 1'b1))); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && step_n) |=> $stable(cnt_addr)); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && !step_n && cnt_addr == ADDR_TOP) |=>
            (cnt_addr == '0)); // R6

    AST_LOAD_NOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !strobe_n && !step_n) |-> (acc_addr == ext_addr)); // R7

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int  AW       = 16;
    localparam time CLK_PER  = 10ns;
    localparam int  NV       = 16;

    typedef struct packed {
        logic          stb_n;
        logic          stp_n;
        logic          clr_n;
        logic [AW-1:0] ext;
        logic [AW-1:0] acc;
        logic [3:0]    req;
    } vec_t;

    // stb_n, stp_n, clr_n, ext, expected acc_addr, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 16'h1234, 16'h0000, 4'd5}, // R5 hold, ext ignored
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h0001, 4'd4}, // R4 step
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h0002, 4'd4}, // R4 step
        '{1'b0, 1'b1, 1'b1, 16'h0100, 16'h0100, 4'd3}, // R3 load
        '{1'b1, 1'b0, 1'b1, 16'h9999, 16'h0101, 4'd4}, // R4 step after load
        '{1'b1, 1'b1, 1'b1, 16'hBEEF, 16'h0101, 4'd5}, // R5 hold
        '{1'b0, 1'b0, 1'b1, 16'h2000, 16'h2000, 4'd7}, // R7 load beats step
        '{1'b0, 1'b0, 1'b0, 16'h5555, 16'h0000, 4'd2}, // R2 clear beats all
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h0001, 4'd4}, // R4 step from zero
        '{1'b1, 1'b1, 1'b0, 16'h7777, 16'h0000, 4'd2}, // R2 clear alone
        '{1'b0, 1'b1, 1'b1, 16'hFFFE, 16'hFFFE, 4'd3}, // R3 load near top
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 4'd4}, // R4 step to top
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h0000, 4'd6}, // R6 wrap
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h0001, 4'd6}, // R6 continue after wrap
        '{1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'd2}, // R2 clear beats step
        '{1'b1, 1'b1, 1'b1, 16'hAAAA, 16'h0000, 4'd5}  // R5 hold at zero
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ext_addr;
    logic          strobe_n, step_n, clr_n;
    logic [AW-1:0] acc_addr, cnt_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk      (clk),
        .rst      (rst),
        .ext_addr (ext_addr),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .acc_addr (acc_addr),
        .cnt_addr (cnt_addr)
    );

    task automatic chk(input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic e, input logic c,
                         input logic [AW-1:0] a);
        @(negedge clk);
        strobe_n = s; step_n = e; clr_n = c; ext_addr = a;
        #1;
    endtask

    initial begin
        logic [AW-1:0] prev;
        rst = 1'b1; strobe_n = 1'b1; step_n = 1'b1; clr_n = 1'b1;
        ext_addr = 16'h3C3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 counter after reset", cnt_addr, 16'h0000);
        chk("R1 access address after reset", acc_addr, 16'h0000);

        // vector walk: acc_addr due this cycle, cnt_addr one edge later
        prev = '0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].stb_n, VEC[i].stp_n, VEC[i].clr_n, VEC[i].ext);
            chk($sformatf("R%0d vector %0d acc_addr", VEC[i].req, i),
                acc_addr, VEC[i].acc);
            chk($sformatf("R%0d vector %0d cnt_addr", VEC[i].req, i),
                cnt_addr, prev);
            prev = VEC[i].acc;
        end

        // R5: external address wiggles during hold, counter untouched
        drive(1'b0, 1'b1, 1'b1, 16'h0420);
        drive(1'b1, 1'b1, 1'b1, 16'hFFFF);
        drive(1'b1, 1'b1, 1'b1, 16'h0001);
        chk("R5 hold ignores ext (acc)", acc_addr, 16'h0420);
        chk("R5 hold ignores ext (cnt)", cnt_addr, 16'h0420);

        // R6: long burst across the top of the space
        drive(1'b0, 1'b1, 1'b1, 16'hFFFC);
        for (int k = 0; k < 6; k++) begin
            drive(1'b1, 1'b0, 1'b1, 16'h0000);
            chk($sformatf("R6 burst step %0d", k), acc_addr,
                AW'(16'hFFFC + k + 1));
        end
        drive(1'b1, 1'b1, 1'b1, 16'h0000);
        chk("R6 counter after wrap burst", cnt_addr, 16'h0002);

        // R2: clear in the middle of a burst, then step resumes from 1
        drive(1'b1, 1'b0, 1'b0, 16'h0000);
        chk("R2 clear mid-burst acc", acc_addr, 16'h0000);
        drive(1'b1, 1'b0, 1'b1, 16'h0000);
        chk("R2 step after clear acc", acc_addr, 16'h0001);
        chk("R2 counter after clear", cnt_addr, 16'h0000);

        // R1: system reset mid-run
        drive(1'b0, 1'b1, 1'b1, 16'h4444);
        drive(1'b1, 1'b1, 1'b1, 16'h0000);
        chk("R3 load before system reset", cnt_addr, 16'h4444);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 counter after mid-run reset", cnt_addr, 16'h0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PER * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule